// File: doc/BRIEF.md
# Receive Message FIFO Status Tracker

This block keeps whole received frames in a small first-in first-out store and reports its state to a host. A receive-side source pushes one frame per cycle. The host pops frames one at a time, and each frame comes back on a registered data output in the cycle after the pop.

The block keeps a fill counter and three flags: not-empty, critical level reached, and overrun. It packs them into a 32-bit status word. When the store is full, a new frame replaces the oldest stored frame; it is not dropped, and the overrun flag is set. The block also emits one-cycle event pulses, which separate interrupt-status registers outside this block collect.

A single clear input returns the store and all status to the empty state. The controller drives it when it leaves its configuration state, when it enters startup, or when it is told to clear its RAMs. A threshold input sets the critical level.

Top module: `rx_msg_fifo_status`

## Requirements
- R1: While `rst` or `clr_i` is high, the next clock edge empties the store and zeroes `status_o`, every event output and `pop_data_o`. `clr_i` wins over any push or pop in the same cycle.
- R2: Frames come out in the order they were pushed. After a pop on a non-empty store, the popped frame appears on `pop_data_o` in the next cycle. In every other cycle `pop_data_o` is zero.
- R3: `status_o[15:8]` holds the number of stored unread frames, and it never exceeds DEPTH. Bits 31:16 and 7:3 always read 0.
- R4: `status_o[0]` (not-empty) is 1 exactly when the fill level is nonzero. `evt_ne_o` pulses for one cycle, aligned with the status update, for each stored frame.
- R5: `status_o[1]` (critical) is 1 exactly when the fill level is greater than or equal to `crit_level_i`. `evt_crit_o` pulses only when this bit goes from 0 to 1.
- R6: A push while the store is full and no pop is served overwrites the oldest frame. The fill level stays at DEPTH, `status_o[2]` (overrun) is set and `evt_ovr_o` pulses.
- R7: The overrun bit stays set until the next pop that is served on a non-empty store. That pop clears it.
- R8: A push and a pop in the same cycle on a full store serve the pop first, returning the oldest frame. The new frame is then stored normally, with no overrun and no `evt_ovr_o`.
- R9: A pop on an empty store returns zero data and leaves the fill level and the flags as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Synchronous clear of store and status |
| push_valid_i | input | 1 | Store one received frame this cycle |
| push_data_i | input | DATA_W | Frame to store |
| pop_i | input | 1 | Host read of the oldest frame |
| crit_level_i | input | 8 | Critical fill threshold |
| pop_data_o | output | DATA_W | Popped frame, valid the cycle after the pop |
| status_o | output | 32 | Status word: bit0 not-empty, bit1 critical, bit2 overrun, 15:8 fill |
| evt_ne_o | output | 1 | Pulse per stored frame |
| evt_crit_o | output | 1 | Pulse on critical flag rising |
| evt_ovr_o | output | 1 | Pulse on overwrite of the oldest frame |

## Verification
The store runs with a depth of four and is driven with several kinds of stimulus. Directed fill-to-full sequences separate a normal store from an overwrite. Simultaneous push and pop on a full store separates pop-first service from a false overrun. Pops on an empty store confirm that they change nothing. Long random mixes of push, pop and occasional clear, with the threshold swept from 0 to 5 and the push bias varied, tell apart a critical flag that is compared with `>=` from one compared with `>`, and a pulse on the rising edge only from a pulse on every cycle the level is held. A queue model in the bench predicts every output in every cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int NE_BIT    = 0;
  localparam int CRIT_BIT  = 1;
  localparam int OVR_BIT   = 2;
  localparam int FILL_LSB  = 8;
  localparam int FILL_W    = 8;
  localparam int STATUS_W  = 32;

  typedef struct packed {
    logic ovr;
    logic crit;
    logic ne;
  } rxq_flags_t;
endpackage

// File: rtl/rxq_storage.sv
module rxq_storage #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  // read-before-write on a shared address returns the old word
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/rxq_ptr_ctrl.sv
module rxq_ptr_ctrl #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  output logic          pop_hit,
  output logic          push_ok,
  output logic          overwrite,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_d,
  output logic          ovr_q,
  output logic          hit_q
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic empty, full, ovr_d;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == FULL_CNT);
  assign pop_hit   = pop && !empty && !clr;
  assign push_ok   = push && !clr;
  assign overwrite = push_ok && full && !pop_hit;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                                cnt_d = '0;
    else if (push_ok && !pop_hit && !full)  cnt_d = cnt_q + 1'b1;
    else if (pop_hit && !push_ok)           cnt_d = cnt_q - 1'b1;
  end

  always_comb begin
    ovr_d = ovr_q;
    if (clr)            ovr_d = 1'b0;
    else if (overwrite) ovr_d = 1'b1;
    else if (pop_hit)   ovr_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
      ovr_q  <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      if (push_ok)              wr_ptr <= ptr_inc(wr_ptr);
      if (pop_hit || overwrite) rd_ptr <= ptr_inc(rd_ptr);
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
      hit_q <= pop_hit;
    end
  end
endmodule

// File: rtl/rxq_flag_gen.sv
module rxq_flag_gen
  import rxq_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic [CW-1:0]       cnt_d,
  input  logic [CW-1:0]       cnt_q,
  input  logic                ovr_q,
  input  logic [7:0]          thr,
  input  logic                push_ok,
  input  logic                overwrite,
  output logic [STATUS_W-1:0] status,
  output logic                evt_ne,
  output logic                evt_crit,
  output logic                evt_ovr
);
  rxq_flags_t        flg;
  logic              crit_d;
  logic [FILL_W-1:0] fill_ext;

  assign crit_d   = (FILL_W'(cnt_d) >= thr);
  assign fill_ext = FILL_W'(cnt_q);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      flg.ne   <= 1'b0;
      flg.crit <= 1'b0;
      evt_ne   <= 1'b0;
      evt_crit <= 1'b0;
      evt_ovr  <= 1'b0;
    end else begin
      flg.ne   <= (cnt_d != '0);
      flg.crit <= crit_d;
      evt_ne   <= push_ok;
      evt_crit <= crit_d && !flg.crit;
      evt_ovr  <= overwrite;
    end
  end

  assign flg.ovr = ovr_q;

  always_comb begin
    status = '0;
    status[NE_BIT]   = flg.ne;
    status[CRIT_BIT] = flg.crit;
    status[OVR_BIT]  = flg.ovr;
    status[FILL_LSB +: FILL_W] = fill_ext;
  end
endmodule

// File: rtl/rx_msg_fifo_status.sv
module rx_msg_fifo_status #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              push_valid_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic [7:0]        crit_level_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic [31:0]       status_o,
  output logic              evt_ne_o,
  output logic              evt_crit_o,
  output logic              evt_ovr_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          pop_hit, push_ok, overwrite, ovr_q, hit_q;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DATA_W-1:0] ram_q;

  rxq_ptr_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptr (
    .clk(clk), .rst(rst), .clr(clr_i), .push(push_valid_i), .pop(pop_i),
    .pop_hit(pop_hit), .push_ok(push_ok), .overwrite(overwrite),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .cnt_q(cnt_q), .cnt_d(cnt_d),
    .ovr_q(ovr_q), .hit_q(hit_q)
  );

  rxq_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .wr_en(push_ok), .wr_addr(wr_ptr), .wr_data(push_data_i),
    .rd_en(pop_hit), .rd_addr(rd_ptr), .rd_data(ram_q)
  );

  rxq_flag_gen #(.CW(CW)) u_flags (
    .clk(clk), .rst(rst), .clr(clr_i), .cnt_d(cnt_d), .cnt_q(cnt_q),
    .ovr_q(ovr_q), .thr(crit_level_i), .push_ok(push_ok),
    .overwrite(overwrite), .status(status_o), .evt_ne(evt_ne_o),
    .evt_crit(evt_crit_o), .evt_ovr(evt_ovr_o)
  );

  assign pop_data_o = hit_q ? ram_q : '0;
endmodule

// File: rtl/rx_msg_fifo_status_chk.sv
module rx_msg_fifo_status_chk #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_i,
  input logic              push_valid_i,
  input logic              pop_i,
  input logic [DATA_W-1:0] pop_data_o,
  input logic [31:0]       status_o,
  input logic              evt_ne_o,
  input logic              evt_crit_o,
  input logic              evt_ovr_o
);
  logic [7:0] fill;
  assign fill = status_o[15:8];

  assert_clear_zeroes_R1: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (status_o == 32'd0 && !evt_ne_o && !evt_crit_o && !evt_ovr_o));

  assert_fill_bounded_R3: assert property (@(posedge clk) disable iff (rst)
    (32'(fill) <= DEPTH) && (status_o[31:16] == 16'd0) && (status_o[7:3] == 5'd0));

  assert_ne_tracks_fill_R4: assert property (@(posedge clk) disable iff (rst)
    status_o[0] == (fill != 8'd0));

  assert_ne_event_flag_R4: assert property (@(posedge clk) disable iff (rst)
    evt_ne_o |-> status_o[0]);

  assert_crit_event_edge_R5: assert property (@(posedge clk) disable iff (rst)
    evt_crit_o |-> (status_o[1] && !$past(status_o[1])));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && push_valid_i && !pop_i && 32'(fill) == DEPTH)
      |=> (evt_ovr_o && status_o[2] && 32'(fill) == DEPTH));

  assert_pop_clears_ovr_R7: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && pop_i && fill != 8'd0) |=> !status_o[2]);

  assert_full_pushpop_R8: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && push_valid_i && pop_i && 32'(fill) == DEPTH)
      |=> (!evt_ovr_o && 32'(fill) == DEPTH));

  assert_empty_pop_R9: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && pop_i && !push_valid_i && fill == 8'd0)
      |=> (pop_data_o == '0 && fill == 8'd0));
endmodule

bind rx_msg_fifo_status rx_msg_fifo_status_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .clr_i(clr_i), .push_valid_i(push_valid_i), .pop_i(pop_i),
  .pop_data_o(pop_data_o), .status_o(status_o), .evt_ne_o(evt_ne_o),
  .evt_crit_o(evt_crit_o), .evt_ovr_o(evt_ovr_o)
);

// File: tb/test_rx_msg_fifo_status.sv
module test_rx_msg_fifo_status;
  localparam int DW = 8;
  localparam int D  = 4;

  logic clk = 1'b0;
  logic rst, clr_i, push_valid_i, pop_i;
  logic [DW-1:0] push_data_i, pop_data_o;
  logic [7:0]  crit_level_i;
  logic [31:0] status_o;
  logic evt_ne_o, evt_crit_o, evt_ovr_o;

  int compared = 0;
  int mismatched = 0;
  string phase = "init";

  logic [DW-1:0] mq[$];
  logic e_ovr = 1'b0, e_crit = 1'b0;
  logic [DW-1:0] dseq = 8'h10;

  always #2 clk = ~clk;

  rx_msg_fifo_status #(.DATA_W(DW), .DEPTH(D)) i_rx_msg_fifo_status (
    .clk(clk), .rst(rst), .clr_i(clr_i), .push_valid_i(push_valid_i),
    .push_data_i(push_data_i), .pop_i(pop_i), .crit_level_i(crit_level_i),
    .pop_data_o(pop_data_o), .status_o(status_o), .evt_ne_o(evt_ne_o),
    .evt_crit_o(evt_crit_o), .evt_ovr_o(evt_ovr_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL [%s] %s act=%0h exp=%0h", phase, tag, act, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic c, input logic p, input logic q,
                     input logic [7:0] th);
    logic [DW-1:0] x_d;
    logic x_ne, x_cr, x_ov, newc;
    rst = r; clr_i = c; push_valid_i = p; pop_i = q; crit_level_i = th;
    push_data_i = dseq;
    @(posedge clk);
    x_d = '0; x_ne = 1'b0; x_cr = 1'b0; x_ov = 1'b0;
    if (r || c) begin
      mq.delete(); e_ovr = 1'b0; e_crit = 1'b0;
    end else begin
      if (q && mq.size() > 0) begin x_d = mq.pop_front(); e_ovr = 1'b0; end
      if (p) begin
        if (mq.size() == D) begin void'(mq.pop_front()); e_ovr = 1'b1; x_ov = 1'b1; end
        mq.push_back(dseq); x_ne = 1'b1; dseq = dseq + 8'd1;
      end
      newc = (mq.size() >= int'(th));
      x_cr = newc && !e_crit;
      e_crit = newc;
    end
    @(negedge clk);
    if (r || c) chk("R1 status cleared", status_o, 32'd0);
    chk("R3 fill level", {24'd0, status_o[15:8]}, 32'(mq.size()));
    chk("R3 reserved bits", status_o & 32'hFFFF00F8, 32'd0);
    chk("R4 not-empty bit", {31'd0, status_o[0]}, {31'd0, mq.size() != 0});
    chk("R5 critical bit", {31'd0, status_o[1]}, {31'd0, e_crit});
    chk("R7 overrun bit", {31'd0, status_o[2]}, {31'd0, e_ovr});
    chk("R4 evt_ne", {31'd0, evt_ne_o}, {31'd0, x_ne});
    chk("R5 evt_crit", {31'd0, evt_crit_o}, {31'd0, x_cr});
    chk("R6 evt_ovr", {31'd0, evt_ovr_o}, {31'd0, x_ov});
    chk("R2 pop data", {24'd0, pop_data_o}, {24'd0, x_d});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst = 1'b1; clr_i = 1'b0; push_valid_i = 1'b0; pop_i = 1'b0;
    crit_level_i = 8'd3; push_data_i = '0;
    @(negedge clk);
    phase = "R1 reset";
    cyc(1, 0, 0, 0, 8'd3);
    cyc(1, 0, 1, 1, 8'd3);

    phase = "R9 empty pop";
    cyc(0, 0, 0, 1, 8'd3);
    cyc(0, 0, 0, 1, 8'd3);

    phase = "R2 fill order";
    for (int i = 0; i < D; i++) cyc(0, 0, 1, 0, 8'd3);

    phase = "R6 overwrite";
    cyc(0, 0, 1, 0, 8'd3);
    cyc(0, 0, 1, 0, 8'd3);

    phase = "R7 sticky";
    cyc(0, 0, 0, 0, 8'd3);
    cyc(0, 0, 0, 1, 8'd3);

    phase = "R8 full push+pop";
    cyc(0, 0, 1, 0, 8'd3);
    cyc(0, 0, 1, 1, 8'd3);
    cyc(0, 0, 1, 1, 8'd3);

    phase = "R5 threshold edge";
    cyc(0, 0, 0, 1, 8'd4);
    cyc(0, 0, 0, 0, 8'd2);
    cyc(0, 0, 0, 0, 8'd5);
    cyc(0, 0, 0, 0, 8'd3);

    phase = "R2 drain";
    for (int i = 0; i < D + 1; i++) cyc(0, 0, 0, 1, 8'd3);

    phase = "R1 clear";
    cyc(0, 0, 1, 0, 8'd1);
    cyc(0, 0, 1, 0, 8'd1);
    cyc(0, 1, 1, 1, 8'd1);
    cyc(0, 0, 0, 0, 8'd0);

    phase = "sweep";
    for (int th = 0; th <= 5; th++) begin
      for (int n = 0; n < 400; n++) begin
        logic p, q, c;
        p = (($urandom % 8) < ((th % 2 == 0) ? 6 : 3));
        q = (($urandom % 8) < ((th % 2 == 0) ? 2 : 5));
        c = (($urandom % 64) == 0);
        cyc(0, c, p, q, 8'(th));
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule